// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller connects a simple processor-side request port to an asynchronous dynamic memory of 2M bytes whose address pins carry the row and the column one after the other. A request presents a 21-bit byte address, a direction flag and a beat count. The controller splits the address into a 12-bit row and a 9-bit column. It opens the row with a falling row strobe, then latches one or more columns with falling column strobes, and closes the row with a timed precharge. Multi-byte transfers use page mode: the row stays open and each further byte costs only one column strobe.

Refresh needs no help from the processor. A cycle counter marks a refresh as due once per interval, 488 cycles by default, which spreads a 16 ms budget over 4096 rows at 125 MHz. The controller then performs a row-strobe-only cycle on the row named by an internal counter. A due refresh runs as soon as the current access ends, and it goes ahead of any waiting request. All strobe widths and gaps are parameters counted in clock cycles.

Top module: `adram_ctrl`

## Requirements
- R1: The row is `addr[20:9]` and is driven on `dram_addr` before `dram_ras_n` falls. The column of beat k is `addr[8:0]`+k, zero-extended, and is driven before `dram_cas_n` falls. Each value holds while its strobe falls.
- R2: `dram_cas_n` goes low only while `dram_ras_n` is low, and `dram_cs_n` is low whenever `dram_ras_n` is low.
- R3: Each column strobe stays low for exactly T_CAS cycles. The row strobe precedes the first column strobe by at least T_RCD cycles. The row strobe stays high for at least T_RP cycles before it falls again.
- R4: With `rd`=1, `dram_rw` is high, and the byte the memory returns is presented on `rdata` in the same cycle as `done`.
- R5: With `rd`=0, `dram_rw` is low and `dram_dq_oe` is high. The value on `wdata` at each column strobe is driven on `dram_dq_out`. `dram_rw` does not change while `dram_cas_n` is low.
- R6: A request carries `len_m1`+1 bytes. The row strobe stays low for the whole burst, and the column advances by one per beat, wrapping from 511 to 0 within the same row.
- R7: `done` is a one-cycle pulse, given once per byte transferred.
- R8: `ready` is high only when the controller is idle and no refresh is due. A `req` while `ready` is low is ignored and changes no memory content. No `done` appears without an accepted request.
- R9: A refresh is a row-strobe cycle with no column strobe. It drives an internal row number that starts at 0 after reset and increases by one per refresh, modulo 4096.
- R10: A refresh falls due every REF_INTERVAL cycles and starts no later than the end of the access in progress. It takes priority over a waiting request.
- R11: During reset all strobes and `dram_cs_n` are high, `done` and `dram_dq_oe` are low, and `ready` is high once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, taken while `ready` is high |
| addr | input | 21 | Byte address of the first beat |
| rd | input | 1 | 1 = read, 0 = write |
| len_m1 | input | 4 | Burst length minus one |
| wdata | input | 8 | Write byte for the current beat |
| ready | output | 1 | Controller idle with no refresh due |
| done | output | 1 | One-cycle pulse per completed byte |
| rdata | output | 8 | Read byte, valid with `done` |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_rw | output | 1 | 1 = read, 0 = write |
| dram_dq_out | output | 8 | Write data toward the memory |
| dram_dq_oe | output | 1 | Write data drive enable |
| dram_dq_in | input | 8 | Read data from the memory |

## Verification
The strobe-timing properties assume that the timing parameters are at least one, and that the processor raises `req` only while `ready` is high. The bench honours this by waiting for `ready` before each request. The single out-of-window request it makes is meant to be ignored. The write-data properties also assume that a new `wdata` byte arrives between a `done` and the next column strobe. The driver changes `wdata` right after each `done`, which is well before the falling edge of the next column strobe. The memory model samples its data on the falling column strobe, so the bench meets this window without relying on any internal signal.

// File: rtl/adram_ctrl.sv
module adram_ctrl #(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 8,
  parameter int LEN_W        = 4,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 1,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 5,
  parameter int REF_INTERVAL = 488
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic [ROW_W+COL_W-1:0]  addr,
  input  logic                    rd,
  input  logic [LEN_W-1:0]        len_m1,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    ready,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_cas_n,
  output logic                    dram_cs_n,
  output logic                    dram_rw,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TA    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TB    = (TA > T_CP) ? TA : T_CP;
  localparam int TC    = (TB > T_RP) ? TB : T_RP;
  localparam int TMAX  = (TC > T_RAS) ? TC : T_RAS;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);
  localparam logic [REF_W-1:0] REF_LOAD = REF_W'(REF_INTERVAL - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RSET, S_RCD, S_CSET, S_CASL, S_REF, S_PRE
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [COL_W-1:0]  col_q;
  logic [LEN_W-1:0]  beats;
  logic              rd_q, ref_q, ref_pend;
  logic [REF_W-1:0]  ref_timer;
  logic [ROW_W-1:0]  ref_row;
  logic [MUX_W-1:0]  mux_q;
  logic              ras_q, cas_q, done_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cnt_zero;

  assign cnt_zero    = (cnt == '0);
  assign ready       = (st == S_IDLE) && !ref_pend;
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign dram_addr   = mux_q;
  assign dram_ras_n  = ras_q;
  assign dram_cas_n  = cas_q;
  assign dram_cs_n   = (st == S_IDLE);
  assign dram_rw     = rd_q;
  assign dram_dq_oe  = ~rd_q;
  assign dram_dq_out = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      col_q     <= '0;
      beats     <= '0;
      rd_q      <= 1'b1;
      ref_q     <= 1'b0;
      ref_pend  <= 1'b0;
      ref_timer <= REF_LOAD;
      ref_row   <= '0;
      mux_q     <= '0;
      ras_q     <= 1'b1;
      cas_q     <= 1'b1;
      done_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            ref_pend <= 1'b0;
            ref_q    <= 1'b1;
            rd_q     <= 1'b1;
            mux_q    <= MUX_W'(ref_row);
            st       <= S_RSET;
          end else if (req) begin
            ref_q <= 1'b0;
            rd_q  <= rd;
            col_q <= addr[COL_W-1:0];
            beats <= len_m1;
            mux_q <= MUX_W'(addr[ROW_W+COL_W-1:COL_W]);
            st    <= S_RSET;
          end
        end
        S_RSET: begin
          ras_q <= 1'b0;
          cnt   <= ref_q ? CNT_W'(T_RAS - 1) : CNT_W'(T_RCD - 1);
          st    <= ref_q ? S_REF : S_RCD;
        end
        S_RCD: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            mux_q <= MUX_W'(col_q);
            cnt   <= CNT_W'(T_CP - 1);
            st    <= S_CSET;
          end
        end
        S_CSET: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            cas_q <= 1'b0;
            cnt   <= CNT_W'(T_CAS - 1);
            st    <= S_CASL;
          end
        end
        S_CASL: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            cas_q  <= 1'b1;
            done_q <= 1'b1;
            if (rd_q) rdata_q <= dram_dq_in;
            if (beats == '0) begin
              ras_q <= 1'b1;
              rd_q  <= 1'b1;
              cnt   <= CNT_W'(T_RP - 1);
              st    <= S_PRE;
            end else begin
              beats <= beats - 1'b1;
              col_q <= col_q + 1'b1;
              mux_q <= MUX_W'(COL_W'(col_q + 1'b1));
              cnt   <= CNT_W'(T_CP - 1);
              st    <= S_CSET;
            end
          end
        end
        S_REF: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else begin
            ras_q   <= 1'b1;
            ref_row <= ref_row + 1'b1;
            cnt     <= CNT_W'(T_RP - 1);
            st      <= S_PRE;
          end
        end
        S_PRE: begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (ref_timer == '0) begin
        ref_timer <= REF_LOAD;
        ref_pend  <= 1'b1;
      end else begin
        ref_timer <= ref_timer - 1'b1;
      end
    end
  end
endmodule

module adram_ctrl_chk #(
  parameter int MUX_W = 12,
  parameter int T_RCD = 3,
  parameter int T_CAS = 2,
  parameter int T_RP  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic             dram_cs_n,
  input logic             dram_rw,
  input logic             done,
  input logic             ready,
  input logic [MUX_W-1:0] dram_addr
);
  logic [7:0] cas_lo, ras_lo, ras_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cas_lo <= '0;
      ras_lo <= '0;
      ras_hi <= 8'(T_RP);
    end else begin
      cas_lo <= dram_cas_n ? 8'd0 : ((cas_lo == 8'hFF) ? cas_lo : cas_lo + 1'b1);
      ras_lo <= dram_ras_n ? 8'd0 : ((ras_lo == 8'hFF) ? ras_lo : ras_lo + 1'b1);
      ras_hi <= !dram_ras_n ? 8'd0 : ((ras_hi == 8'hFF) ? ras_hi : ras_hi + 1'b1);
    end
  end

  p_row_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $stable(dram_addr));
  p_col_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> $stable(dram_addr));
  p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  p_cs_covers_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> !dram_cs_n);
  p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> (cas_lo >= 8'(T_CAS)));
  p_ras_to_cas_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_lo >= 8'(T_RCD)));
  p_ras_precharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi >= 8'(T_RP)));
  p_rw_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_rw));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (dram_ras_n && dram_cas_n && dram_cs_n));
endmodule

bind adram_ctrl adram_ctrl_chk #(
  .MUX_W(MUX_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_cs_n(dram_cs_n), .dram_rw(dram_rw), .done(done), .ready(ready),
  .dram_addr(dram_addr)
);

// File: tb/sim_adram_ctrl.sv
`timescale 1ns/1ps
module sim_adram_ctrl;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_RAS = 3;
  localparam int REF_I = 200, SLACK = 60, WDOG = 150000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, rd, ready, done;
  logic [20:0] addr;
  logic [3:0]  len_m1;
  logic [7:0]  wdata, rdata, dram_dq_out;
  logic [7:0]  dram_dq_in = 8'h00;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_cs_n, dram_rw, dram_dq_oe;

  adram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
               .T_RAS(T_RAS), .REF_INTERVAL(REF_I)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .rd(rd), .len_m1(len_m1),
    .wdata(wdata), .ready(ready), .done(done), .rdata(rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_cs_n(dram_cs_n), .dram_rw(dram_rw), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [7:0] fillv(input int a);
    return 8'(a ^ (a >> 7) ^ (a >> 14));
  endfunction

  logic [7:0] dmem [int];
  logic [7:0] shadow [int];
  bit   q_rd [$];
  logic [7:0] q_d [$];
  int   q_a [$];

  function automatic logic [7:0] dev_get(input int a);
    return dmem.exists(a) ? dmem[a] : fillv(a);
  endfunction
  function automatic logic [7:0] sh_get(input int a);
    return shadow.exists(a) ? shadow[a] : fillv(a);
  endfunction

  // behavioural memory: latches row and column on the strobe falls
  int lat_row = 0, t_rf = 0, t_rr = -1000, t_cf = 0;
  bit saw_cas = 0, ras_act = 0;
  int exp_rrow = 0, n_ref = 0, last_ref = -1;

  always @(negedge dram_ras_n) if (rst_n) begin
    ras_act = 1;
    chk(cyc - t_rr >= T_RP, "R3 row precharge", cyc - t_rr, T_RP);
    chk(!dram_cs_n, "R2 select with row strobe", dram_cs_n, 0);
    t_rf = cyc;
    saw_cas = 0;
    lat_row = int'(dram_addr);
  end

  always @(posedge dram_ras_n) if (ras_act) begin
    ras_act = 0;
    t_rr = cyc;
    if (!saw_cas) begin
      n_ref++;
      chk(lat_row == exp_rrow, "R9 refresh row", lat_row, exp_rrow);
      exp_rrow = (exp_rrow + 1) % 4096;
      if (last_ref >= 0)
        chk((t_rf - last_ref >= REF_I - SLACK) && (t_rf - last_ref <= REF_I + SLACK),
            "R10 refresh spacing", t_rf - last_ref, REF_I);
      last_ref = t_rf;
    end
  end

  always @(negedge dram_cas_n) if (rst_n) begin
    int a, e;
    saw_cas = 1;
    t_cf = cyc;
    chk(!dram_ras_n, "R2 column strobe inside row strobe", dram_ras_n, 0);
    chk(cyc - t_rf >= T_RCD, "R3 row-to-column delay", cyc - t_rf, T_RCD);
    a = (lat_row << 9) | int'(dram_addr[8:0]);
    if (q_a.size() == 0) chk(0, "R8 unexpected column strobe", a, -1);
    else begin
      e = q_a.pop_front();
      chk(a == e, "R1 R6 byte address", a, e);
    end
    if (dram_rw) dram_dq_in = dev_get(a);
    else begin
      chk(dram_dq_oe, "R5 write drive enable", dram_dq_oe, 1);
      dmem[a] = dram_dq_out;
    end
  end

  always @(posedge dram_cas_n) if (rst_n && saw_cas)
    chk(cyc - t_cf == T_CAS, "R3 column strobe width", cyc - t_cf, T_CAS);

  // scoreboard monitor
  bit prev_done = 0;
  always @(negedge clk) if (rst_n) begin
    bit r;
    logic [7:0] e;
    if (done) begin
      chk(!prev_done, "R7 done pulse width", 2, 1);
      if (q_rd.size() == 0) chk(0, "R8 done without request", 1, 0);
      else begin
        r = q_rd.pop_front();
        e = q_d.pop_front();
        if (r) chk(rdata == e, "R4 read data", rdata, e);
      end
    end
    prev_done = done;
  end

  task automatic access(input int a, input bit r, input int nm1,
                        input bit poke, input int poke_a);
    int ad;
    logic [7:0] wq [16];
    @(negedge clk);
    while (!ready) @(negedge clk);
    for (int k = 0; k <= nm1; k++) begin
      ad = (a & ~511) | ((a + k) & 511);
      q_a.push_back(ad);
      q_rd.push_back(r);
      if (r) q_d.push_back(sh_get(ad));
      else begin
        wq[k] = 8'(ad * 37 + k * 11 + 91);
        shadow[ad] = wq[k];
        q_d.push_back(wq[k]);
      end
    end
    req = 1'b1; addr = 21'(a); rd = r; len_m1 = 4'(nm1);
    wdata = r ? 8'h00 : wq[0];
    @(negedge clk);
    if (poke) begin
      chk(!ready, "R8 ready low while busy", ready, 0);
      addr = 21'(poke_a); rd = 1'b0; wdata = 8'hEE; len_m1 = 4'd0;
      @(negedge clk);
    end
    req = 1'b0;
    if (!r)
      for (int k = 1; k <= nm1; k++) begin
        do @(negedge clk); while (!done);
        wdata = wq[k];
      end
  endtask

  task automatic drain();
    while (q_rd.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog actual %0d expected below %0d", cyc, WDOG);
    finish_run();
  end

  initial begin
    int s, a, start;
    rst_n = 1'b0; req = 1'b0; addr = '0; rd = 1'b1; len_m1 = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n === 1'b1, "R11 row strobe in reset", dram_ras_n, 1);
    chk(dram_cas_n === 1'b1, "R11 column strobe in reset", dram_cas_n, 1);
    chk(dram_cs_n === 1'b1, "R11 select in reset", dram_cs_n, 1);
    chk(done === 1'b0, "R11 done in reset", done, 0);
    chk(dram_dq_oe === 1'b0, "R11 drive enable in reset", dram_dq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready === 1'b1, "R11 ready after reset", ready, 1);
    start = cyc;

    access(21'h12345, 0, 0, 0, 0);                 // R5 single write
    access(21'h12345, 1, 0, 0, 0);                 // R4 single read
    access((5 << 9) | 100, 0, 7, 0, 0);            // R6 page write
    access((5 << 9) | 100, 1, 7, 0, 0);            // R6 page read
    access((9 << 9) | 510, 0, 3, 0, 0);            // R6 column wrap
    access((9 << 9) | 510, 1, 3, 0, 0);
    access((77 << 9), 1, 15, 1, (3 << 9) | 3);     // R8 request while busy
    access((3 << 9) | 3, 1, 0, 0, 0);              // R8 target left untouched
    s = 1;
    for (int i = 0; i < 40; i++) begin
      s = s * 1103515245 + 12345;
      a = (s >>> 8) & 32'h1FFFFF;
      access(a, 0, i % 16, 0, 0);
      access(a, 1, i % 16, 0, 0);
    end
    drain();
    repeat (3 * REF_I) @(negedge clk);
    chk(n_ref >= (cyc - start) / REF_I - 1, "R10 refresh count", n_ref, (cyc - start) / REF_I - 1);
    chk(n_ref >= 3, "R9 refreshes seen", n_ref, 3);
    chk(q_a.size() == 0, "R6 pending beats", q_a.size(), 0);
    chk(q_rd.size() == 0, "R7 missing done", q_rd.size(), 0);
    finish_run();
  end
endmodule